// File: doc/BRIEF.md
# Two-Register Accumulator Processor Core

This block is a compact multi-cycle processor for a one-address instruction set. It has no register file. Every instruction works on an implicit register, and the opcode picks which one: the accumulator or a second register called the subtractor. Choosing the subtractor costs no extra instruction bytes. Instructions that take a memory operand carry a two-byte address after the opcode. Increment, decrement, zero and halt are one byte long.

The core fetches one instruction byte per cycle through a byte-wide instruction port with combinational read data. It reads and writes whole 32-bit words through a data port, also with combinational read data. It stops when it meets a halt instruction or an opcode it does not know. In the second case it also raises an error flag. Only reset restarts it.

Top module: `acc_core`

## Requirements
- R1: Reset, which is active low, clears both registers, the program counter, `halted` and `error`. After reset the core fetches its first opcode from address 0x0000.
- R2: In each opcode byte, bit 7 selects the subtractor (1) or the accumulator (0). Bits 6:0 select the operation: 0x00 halt, 0x01 load, 0x02 store, 0x03 add, 0x04 subtract, 0x05 increment, 0x06 decrement, 0x07 zero, 0x08 branch-if-zero, 0x09 branch-if-nonzero, 0x0A jump.
- R3: Load, store, add, subtract, both branches and jump are three bytes long: the opcode, then the low address byte, then the high address byte. Increment, decrement, zero and halt are one byte long.
- R4: A load copies the addressed word into the selected register. A store writes the selected register to the addressed word.
- R5: Add and subtract combine the selected register with the addressed word (register plus word, or register minus word). The result wraps modulo 2^32 and is written back to the same register.
- R6: Increment and decrement add or subtract one, wrapping modulo 2^32. Zero clears the selected register.
- R7: Branch-if-zero and branch-if-nonzero test the selected register without changing it. When taken, the next opcode comes from the target address. When not taken, the next opcode comes from the byte after the instruction.
- R8: A jump always continues at its target address.
- R9: An instruction never changes the register that it does not select.
- R10: A halt sets `halted`. After that the instruction address stays fixed and no data write occurs until reset.
- R11: An undefined operation code sets both `error` and `halted`. The instruction address stays on the offending opcode.
- R12: A one-byte instruction completes in 1 cycle and an addressed instruction in 4 cycles. A store asserts `dmem_we` for exactly one cycle, in the 4th cycle of the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Instruction byte address (program counter) |
| imem_data | input | 8 | Instruction byte at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 16 | Data word address |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | 32 | Data write word |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, valid in the same cycle |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Core stopped on an undefined opcode |

## Verification
A one-byte instruction does three things in the cycle its opcode is on the instruction port: it decodes, writes its register and advances the fetch address. So a branch that follows directly reads a register value written only one edge earlier. The bench provokes this by placing a subtractor increment directly in front of a branch-if-nonzero on the subtractor. It judges the result by whether execution reaches the target and by the total cycle count at halt. A second collision happens when an undefined opcode is decoded in its own fetch cycle. Here the bench judges that the fetch address does not advance past the bad byte.

// File: rtl/acc_pkg.sv
package acc_pkg;

   typedef enum logic [6:0] {
      OP_HALT  = 7'h00,
      OP_LOAD  = 7'h01,
      OP_STORE = 7'h02,
      OP_ADD   = 7'h03,
      OP_SUB   = 7'h04,
      OP_INC   = 7'h05,
      OP_DEC   = 7'h06,
      OP_ZERO  = 7'h07,
      OP_BEQZ  = 7'h08,
      OP_BNEZ  = 7'h09,
      OP_JMP   = 7'h0A
   } op_e;

   typedef enum logic [2:0] {
      ST_OP,
      ST_LO,
      ST_HI,
      ST_EX,
      ST_STOP
   } state_e;

   typedef enum logic [2:0] {
      ALU_PASS,
      ALU_ADD,
      ALU_SUB,
      ALU_INC,
      ALU_DEC,
      ALU_ZERO
   } alu_e;

   typedef struct packed {
      logic valid;
      logic halt;
      logic has_addr;
      logic wr_reg;
      logic mem_wr;
      logic is_branch;
      logic br_on_zero;
      logic br_always;
      alu_e alu;
   } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_pkg::*;
#(
   parameter int OP_W = 8,
   localparam int SEL_BIT = OP_W - 1
) (
   input  logic [OP_W-1:0] opcode,
   output dec_t            dec,
   output logic            sel
);

   op_e op;

   assign op  = op_e'(opcode[SEL_BIT-1:0]);
   assign sel = opcode[SEL_BIT];

   always_comb begin
      dec       = '0;
      dec.alu   = ALU_PASS;
      dec.valid = 1'b1;
      case (op)
         OP_HALT:  dec.halt = 1'b1;
         OP_LOAD:  begin dec.has_addr = 1'b1; dec.wr_reg = 1'b1; dec.alu = ALU_PASS; end
         OP_STORE: begin dec.has_addr = 1'b1; dec.mem_wr = 1'b1; end
         OP_ADD:   begin dec.has_addr = 1'b1; dec.wr_reg = 1'b1; dec.alu = ALU_ADD; end
         OP_SUB:   begin dec.has_addr = 1'b1; dec.wr_reg = 1'b1; dec.alu = ALU_SUB; end
         OP_INC:   begin dec.wr_reg = 1'b1; dec.alu = ALU_INC; end
         OP_DEC:   begin dec.wr_reg = 1'b1; dec.alu = ALU_DEC; end
         OP_ZERO:  begin dec.wr_reg = 1'b1; dec.alu = ALU_ZERO; end
         OP_BEQZ:  begin dec.has_addr = 1'b1; dec.is_branch = 1'b1; dec.br_on_zero = 1'b1; end
         OP_BNEZ:  begin dec.has_addr = 1'b1; dec.is_branch = 1'b1; end
         OP_JMP:   begin dec.has_addr = 1'b1; dec.br_always = 1'b1; end
         default:  dec.valid = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  alu_e              fn,
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] mem,
   output logic [DATA_W-1:0] res
);

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [DATA_W-1:0] opb;
         logic              cin;
         logic [DATA_W-1:0] sum;

         always_comb begin
            opb = '0;
            cin = 1'b0;
            case (fn)
               ALU_ADD: opb = mem;
               ALU_SUB: begin opb = ~mem; cin = 1'b1; end
               ALU_INC: cin = 1'b1;
               ALU_DEC: opb = '1;
               default: ;
            endcase
         end

         assign sum = cur + opb + DATA_W'(cin);

         always_comb begin
            case (fn)
               ALU_PASS: res = mem;
               ALU_ZERO: res = '0;
               default:  res = sum;
            endcase
         end
      end else begin : g_direct
         always_comb begin
            case (fn)
               ALU_PASS: res = mem;
               ALU_ADD:  res = cur + mem;
               ALU_SUB:  res = cur - mem;
               ALU_INC:  res = cur + DATA_W'(1);
               ALU_DEC:  res = cur - DATA_W'(1);
               default:  res = '0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/acc_regbank.sv
module acc_regbank #(
   parameter int DATA_W = 32,
   parameter int NREG   = 2,
   localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel,
   output logic [DATA_W-1:0] rdata,
   output logic              rzero
);

   logic [DATA_W-1:0] bank [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && (wsel == SEL_W'(g)))
               q <= wdata;
         end
         assign bank[g] = q;
      end
   endgenerate

   assign rdata = bank[rsel];
   assign rzero = (rdata == '0);

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 16,
   parameter int OP_W         = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [OP_W-1:0]   imem_data,
   output logic [ADDR_W-1:0] dmem_addr,
   output logic              dmem_we,
   output logic [DATA_W-1:0] dmem_wdata,
   input  logic [DATA_W-1:0] dmem_rdata,
   output logic              halted,
   output logic              error
);

   localparam int NREG = 2;

   generate
      if (OP_W != 8) begin : g_bad_op
         $error("acc_core: OP_W must be 8");
      end
      if (ADDR_W != 2 * OP_W) begin : g_bad_addr
         $error("acc_core: ADDR_W must be two instruction bytes");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("acc_core: DATA_W too small");
      end
   endgenerate

   state_e            state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [OP_W-1:0]   opc_q;
   logic [OP_W-1:0]   lo_q;
   logic [ADDR_W-1:0] addr_q;
   logic              halted_q;
   logic              error_q;

   logic [OP_W-1:0]   cur_op;
   dec_t              dec;
   logic              sel;
   logic [DATA_W-1:0] rdata;
   logic              rzero;
   logic [DATA_W-1:0] alu_res;
   logic              reg_we;
   logic              take;

   assign cur_op = (state_q == ST_OP) ? imem_data : opc_q;

   acc_decode #(.OP_W(OP_W)) u_dec (
      .opcode (cur_op),
      .dec    (dec),
      .sel    (sel)
   );

   acc_regbank #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .wsel  (sel),
      .wdata (alu_res),
      .rsel  (sel),
      .rdata (rdata),
      .rzero (rzero)
   );

   acc_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .fn  (dec.alu),
      .cur (rdata),
      .mem (dmem_rdata),
      .res (alu_res)
   );

   assign reg_we = dec.wr_reg &&
                   (((state_q == ST_OP) && dec.valid && !dec.has_addr) ||
                    (state_q == ST_EX));

   assign take = dec.br_always || (dec.is_branch && (rzero == dec.br_on_zero));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_OP;
         pc_q     <= '0;
         opc_q    <= '0;
         lo_q     <= '0;
         addr_q   <= '0;
         halted_q <= 1'b0;
         error_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_OP: begin
               if (!dec.valid) begin
                  error_q  <= 1'b1;
                  halted_q <= 1'b1;
                  state_q  <= ST_STOP;
               end else if (dec.halt) begin
                  halted_q <= 1'b1;
                  state_q  <= ST_STOP;
               end else begin
                  pc_q  <= pc_q + ADDR_W'(1);
                  opc_q <= imem_data;
                  if (dec.has_addr)
                     state_q <= ST_LO;
               end
            end
            ST_LO: begin
               lo_q    <= imem_data;
               pc_q    <= pc_q + ADDR_W'(1);
               state_q <= ST_HI;
            end
            ST_HI: begin
               addr_q  <= ADDR_W'({imem_data, lo_q});
               pc_q    <= pc_q + ADDR_W'(1);
               state_q <= ST_EX;
            end
            ST_EX: begin
               if (take)
                  pc_q <= addr_q;
               state_q <= ST_OP;
            end
            default: state_q <= ST_STOP;
         endcase
      end
   end

   assign imem_addr  = pc_q;
   assign dmem_addr  = addr_q;
   assign dmem_we    = (state_q == ST_EX) && dec.mem_wr;
   assign dmem_wdata = rdata;
   assign halted     = halted_q;
   assign error      = error_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] imem_addr,
   input logic              dmem_we,
   input logic              halted,
   input logic              error
);

   assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   assert_halt_pc_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(imem_addr));

   assert_halt_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !dmem_we);

   assert_error_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> halted);

   assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);

   assert_store_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |=> !dmem_we);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .imem_addr (imem_addr),
   .dmem_we   (dmem_we),
   .halted    (halted),
   .error     (error)
);

// File: tb/acc_core_test.sv
module acc_core_test;

   localparam time CLK_PERIOD = 10ns;

   localparam logic [6:0] B_HALT  = 7'h00;
   localparam logic [6:0] B_LOAD  = 7'h01;
   localparam logic [6:0] B_STORE = 7'h02;
   localparam logic [6:0] B_ADD   = 7'h03;
   localparam logic [6:0] B_SUB   = 7'h04;
   localparam logic [6:0] B_INC   = 7'h05;
   localparam logic [6:0] B_DEC   = 7'h06;
   localparam logic [6:0] B_ZERO  = 7'h07;
   localparam logic [6:0] B_BEQZ  = 7'h08;
   localparam logic [6:0] B_BNEZ  = 7'h09;
   localparam logic [6:0] B_JMP   = 7'h0A;
   localparam logic [31:0] MARK   = 32'hA5A5_A5A5;

   // {op[6:0], sel, first word, second word, expected}
   localparam int NVEC = 9;
   localparam logic [103:0] VEC [NVEC] = '{
      {B_ADD,  1'b0, 32'd5,          32'd7,          32'd12},
      {B_ADD,  1'b1, 32'hFFFF_FFFF,  32'd2,          32'd1},
      {B_SUB,  1'b0, 32'd3,          32'd5,          32'hFFFF_FFFE},
      {B_SUB,  1'b1, 32'd100,        32'd1,          32'd99},
      {B_INC,  1'b0, 32'hFFFF_FFFF,  32'd0,          32'd0},
      {B_DEC,  1'b1, 32'd0,          32'd0,          32'hFFFF_FFFF},
      {B_ZERO, 1'b0, 32'd1234,       32'd0,          32'd0},
      {B_LOAD, 1'b1, 32'd9,          32'hDEAD_BEEF,  32'hDEAD_BEEF},
      {B_INC,  1'b1, 32'd41,         32'd0,          32'd42}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] imem_addr;
   logic [7:0]  imem_data;
   logic [15:0] dmem_addr;
   logic        dmem_we;
   logic [31:0] dmem_wdata;
   logic [31:0] dmem_rdata;
   logic        halted;
   logic        error;

   logic [7:0]  imem [256];
   logic [31:0] dmem [64];
   logic [15:0] last_waddr;
   int          n_writes;
   int          n_chk;
   int          n_bad;
   int          wp;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign imem_data  = imem[imem_addr[7:0]];
   assign dmem_rdata = dmem[dmem_addr[5:0]];

   always @(posedge clk) begin
      if (dmem_we) begin
         dmem[dmem_addr[5:0]] <= dmem_wdata;
         last_waddr <= dmem_addr;
         n_writes <= n_writes + 1;
      end
   end

   acc_core uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_we    (dmem_we),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata),
      .halted     (halted),
      .error      (error)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) imem[i] = 8'h7E;
      for (int i = 0; i < 64; i++) dmem[i] = 32'd0;
      wp = 0;
   endtask

   task automatic emit1(input logic [7:0] b);
      imem[wp[7:0]] = b;
      wp++;
   endtask

   task automatic emit3(input logic [7:0] b, input logic [15:0] a);
      emit1(b);
      emit1(a[7:0]);
      emit1(a[15:8]);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(output int cyc);
      cyc = 0;
      while (cyc < 400) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
         if (halted) break;
      end
      if (!halted) check(1'b0, "watchdog run", 32'(cyc), 32'd400);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cyc;
      int wcount;
      n_chk = 0;
      n_bad = 0;
      n_writes = 0;
      last_waddr = '0;
      clear_mem();

      // R1: state during reset
      @(negedge clk);
      check(imem_addr == 16'h0 && !halted && !error && !dmem_we, "R1 reset outputs",
            {imem_addr, 13'd0, halted, error, dmem_we}, 32'd0);

      // table walk: R2 R4 R5 R6 R9 R12
      for (int i = 0; i < NVEC; i++) begin
         logic [6:0]  op;
         logic        sel;
         logic [31:0] m, n, e;
         bit          addressed;
         int          exp_cyc;
         op  = VEC[i][103:97];
         sel = VEC[i][96];
         m   = VEC[i][95:64];
         n   = VEC[i][63:32];
         e   = VEC[i][31:0];
         addressed = !(op == B_INC || op == B_DEC || op == B_ZERO);
         clear_mem();
         emit3({sel, B_LOAD}, 16'h0010);
         if (addressed) emit3({sel, op}, 16'h0011);
         else emit1({sel, op});
         emit3({sel, B_STORE}, 16'h0020);
         emit3({~sel, B_STORE}, 16'h0021);
         emit1({1'b0, B_HALT});
         dmem[16] = m;
         dmem[17] = n;
         dmem[32] = MARK;
         dmem[33] = MARK;
         do_reset();
         run(cyc);
         exp_cyc = addressed ? 17 : 14;
         check(dmem[32] == e, "R4/R5/R6 result", dmem[32], e);
         check(dmem[33] == 32'd0, "R9 other register untouched", dmem[33], 32'd0);
         check(cyc == exp_cyc, "R12 cycle count", 32'(cyc), 32'(exp_cyc));
         check(!error, "R2 valid opcode no error", {31'd0, error}, 32'd0);
      end

      // R3 R12: address byte order, store strobe
      clear_mem();
      emit1({1'b0, B_INC});
      emit3({1'b0, B_STORE}, 16'h0123);
      emit1({1'b0, B_HALT});
      do_reset();
      wcount = n_writes;
      run(cyc);
      check(last_waddr == 16'h0123, "R3 low byte first", {16'd0, last_waddr}, 32'h0123);
      check(dmem[6'h23] == 32'd1, "R4 store value", dmem[6'h23], 32'd1);
      check(cyc == 6, "R12 one-byte and store timing", 32'(cyc), 32'd6);
      check(n_writes - wcount == 1, "R12 single write strobe", 32'(n_writes - wcount), 32'd1);

      // R7 R8 R10: branches, jump, halt freeze
      clear_mem();
      emit3({1'b0, B_BEQZ}, 16'h0010);        // acc==0 after reset: taken (R1)
      wp = 16'h10;
      emit1({1'b1, B_INC});                   // sub = 1
      emit3({1'b1, B_BNEZ}, 16'h0020);        // taken
      wp = 16'h20;
      emit3({1'b1, B_BEQZ}, 16'h0030);        // not taken
      emit3({1'b0, B_BNEZ}, 16'h0040);        // not taken
      emit3({1'b1, B_STORE}, 16'h0022);
      emit3({1'b0, B_JMP}, 16'h0050);
      wp = 16'h50;
      emit1({1'b0, B_HALT});
      do_reset();
      run(cyc);
      check(!error, "R7 branch path no stray opcode", {31'd0, error}, 32'd0);
      check(dmem[34] == 32'd1, "R7 branch leaves register unchanged", dmem[34], 32'd1);
      check(cyc == 26, "R7 path cycle count", 32'(cyc), 32'd26);
      check(imem_addr == 16'h0050, "R8 jump target reached", {16'd0, imem_addr}, 32'h50);
      check(halted, "R10 halted set", {31'd0, halted}, 32'd1);
      wcount = n_writes;
      repeat (5) @(negedge clk);
      check(imem_addr == 16'h0050, "R10 address frozen", {16'd0, imem_addr}, 32'h50);
      check(n_writes == wcount, "R10 no writes after halt", 32'(n_writes), 32'(wcount));

      // R11: undefined opcode
      clear_mem();
      emit1({1'b0, B_INC});
      emit1(8'h55);
      do_reset();
      run(cyc);
      check(error && halted, "R11 error and halted", {30'd0, error, halted}, 32'd3);
      check(imem_addr == 16'h0001, "R11 address on bad opcode", {16'd0, imem_addr}, 32'h1);
      check(cyc == 2, "R11 stop cycle", 32'(cyc), 32'd2);
      repeat (3) @(negedge clk);
      check(imem_addr == 16'h0001 && error, "R11 stays stopped", {16'd0, imem_addr}, 32'h1);

      // R1: reset clears error
      rst_n = 1'b0;
      @(negedge clk);
      check(!error && !halted && imem_addr == 16'h0, "R1 reset clears error",
            {imem_addr, 14'd0, error, halted}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule